// File: doc/BRIEF.md
# Display Controller Control Register Bank

This block is the control and status register bank of a display controller. It has two registers: a control word and a format word. Each register can be written in three ways, chosen by the two low bits of the write address. A plain write replaces the register. A set alias ORs the written bits into the register. A clear alias removes the written bits from the register. Reads are combinational and select only the register. The bank drives the controller's internal active-low reset, its pixel clock enable, its run strobe and the format fields that the datapath decodes.

Software reset follows a hardware handshake:

1. Software sets the soft-reset bit.
2. A fixed number of cycles later, the bank raises the clock-gate bit by itself to show the reset has been taken.
3. Software then clears the clock-gate bit.
4. Software then clears the soft-reset bit, which releases the reset.

If the soft-reset bit is already set, as it is out of power-on reset, clearing it is enough and no new handshake starts. While the soft-reset bit is set, every other field holds its reset value.

Software stops a transfer by requesting that the run bit be cleared. The bit keeps reading 1 until the next frame-done pulse, so the current frame is never cut short. When the keep-running flag is off, the run bit also drops by itself at the end of each frame.

Top module: `lcd_ctrl_regs`

## Requirements
- R1: After the asynchronous reset, the control word reads 0xC0000000 and the format word reads 0x0000004F. At the same time `core_rst_n`, `pix_clk_en` and `run_active` are all 0.
- R2: The write address selects the register with bit 2 (0 for control, 1 for format) and the access mode with bits 1:0. Mode 0 replaces the register, mode 1 ORs the data in, mode 2 clears the bits that are 1 in the data, and mode 3 leaves both registers unchanged. `rd_sel` chooses the register that appears on `rd_data`.
- R3: The control word layout is: bit 0 run, bit 1 master enable, bit 2 keep-running, bits 5:4 word length, bits 10:8 format flags, bit 30 clock gate, bit 31 soft reset. The format word layout is: bits 3:0 byte-lane mask and bits 6:4 outstanding-request depth. All other bits read 0, and the field output ports mirror the stored fields.
- R4: A write that takes the soft-reset bit from 0 to 1 raises the clock-gate bit exactly GATE_DELAY clock edges after the write edge, with no further write.
- R5: While the soft-reset bit is set, or is being set by the current write, all other fields of both registers take their reset values and ignore writes. The run bit drops on that same edge.
- R6: Writing 1 to the soft-reset bit while it is already set starts no handshake, so the clock-gate bit keeps the value software left. Clearing the soft-reset bit releases the reset.
- R7: Clearing the soft-reset bit before the handshake completes cancels it, and the clock-gate bit is never raised.
- R8: `core_rst_n` is the inverse of the soft-reset bit and `pix_clk_en` is the inverse of the clock-gate bit.
- R9: With keep-running set, a request to clear the run bit leaves it reading 1. It reads 0 only after the first `frame_done` pulse in a later cycle; a pulse in the same cycle as the request does not count.
- R10: With keep-running clear, the run bit falls on the first `frame_done` pulse after it was set. A pulse in the same cycle as the set request does not clear it.
- R11: A request that sets the run bit cancels a pending stop. A set-alias or clear-alias write with data bit 0 equal to 0 changes neither the run bit nor a pending stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select in bit 2, access mode in bits 1:0 |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read register select (0 control, 1 format) |
| rd_data | output | 32 | Read data of the selected register |
| frame_done | input | 1 | One-cycle pulse at the end of a frame |
| core_rst_n | output | 1 | Active-low reset for the display core |
| pix_clk_en | output | 1 | Pixel clock enable |
| run_active | output | 1 | Run bit |
| master_en | output | 1 | Master enable field |
| word_len | output | 2 | Word length field |
| fmt_flags | output | 3 | Data format flags |
| pack_mask | output | 4 | Byte-lane mask |
| outstanding | output | 3 | Outstanding-request depth |

## Verification
The risky coincidence is a software request on the run bit landing in the same cycle as a `frame_done` pulse. This covers both a stop request with keep-running set and a set request in single-frame mode. In both cases the pulse must be ignored, so the transfer ends only on a later frame. A second coincidence is the handshake counter expiring while software writes the soft-reset or clock-gate bits. The bench provokes each case with directed writes placed on the same cycle as a pulse or an expiry. It then drives a long seeded random mix of writes in all four modes, interleaved with frame pulses. After every edge it compares both register words and the reset, clock-enable and run pins with a cycle model written from the requirements.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 2;
  localparam int REG_SEL_W = $clog2(NUM_REGS);
  localparam int MODE_W    = 2;
  localparam int ADDR_W    = REG_SEL_W + MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_WRITE = 2'd0,
    MODE_SET   = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_NONE  = 2'd3
  } acc_mode_e;

  // control word field positions
  localparam int CT_RUN    = 0;
  localparam int CT_MASTER = 1;
  localparam int CT_KEEP   = 2;
  localparam int CT_WL_LO  = 4;
  localparam int WL_W      = 2;
  localparam int CT_FMT_LO = 8;
  localparam int FMT_W     = 3;
  localparam int CT_GATE   = 30;
  localparam int CT_SRST   = 31;

  // format word field positions
  localparam int FW_MASK_LO = 0;
  localparam int MASK_W     = 4;
  localparam int FW_OUT_LO  = 4;
  localparam int OUT_W      = 3;

  localparam logic [MASK_W-1:0] MASK_RST = '1;
  localparam logic [OUT_W-1:0]  OUT_RST  = OUT_W'(4);

  localparam logic [DATA_W-1:0] CTRL_SOFT_MASK =
      (DATA_W'(1) << CT_MASTER) | (DATA_W'(1) << CT_KEEP) |
      (((DATA_W'(1) << WL_W) - 1) << CT_WL_LO) |
      (((DATA_W'(1) << FMT_W) - 1) << CT_FMT_LO);

  localparam logic [DATA_W-1:0] FMT_WORD_MASK =
      (((DATA_W'(1) << MASK_W) - 1) << FW_MASK_LO) |
      (((DATA_W'(1) << OUT_W) - 1) << FW_OUT_LO);

  localparam logic [DATA_W-1:0] FMT_WORD_RST =
      (DATA_W'(MASK_RST) << FW_MASK_LO) | (DATA_W'(OUT_RST) << FW_OUT_LO);

endpackage

// File: rtl/lcd_alias_merge.sv
module lcd_alias_merge
  import lcd_regs_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wdata,
  input  acc_mode_e    mode,
  output logic [W-1:0] merged
);

  always_comb begin
    case (mode)
      MODE_WRITE: merged = wdata;
      MODE_SET:   merged = cur | wdata;
      MODE_CLEAR: merged = cur & ~wdata;
      default:    merged = cur;
    endcase
  end

endmodule

// File: rtl/lcd_reset_handshake.sv
module lcd_reset_handshake #(
  parameter int GATE_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we,
  input  logic sw_srst,
  input  logic sw_gate,
  output logic srst_q,
  output logic srst_d,
  output logic gate_q
);

  localparam int CNT_W = $clog2(GATE_DELAY + 1);

  logic             gate_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  always_comb begin
    srst_d = sw_we ? sw_srst : srst_q;
    gate_d = sw_we ? sw_gate : gate_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    start  = !srst_q && srst_d;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(GATE_DELAY - 1);
    end else if (busy_q) begin
      if (!srst_d) begin
        busy_d = 1'b0;
      end else if (cnt_q == '0) begin
        busy_d = 1'b0;
        gate_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b1;
      gate_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      srst_q <= srst_d;
      gate_q <= gate_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_GATE_FROM_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_q) && !$past(sw_we)) |-> $past(busy_q)); // R4

  AST_ABORT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> !busy_q); // R7

  AST_BUSY_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> srst_q); // R6

endmodule

// File: rtl/lcd_run_ctrl.sv
module lcd_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic set_req,
  input  logic clr_req,
  input  logic frame_done,
  input  logic keep_running,
  output logic run_q
);

  logic run_d;
  logic pend_q, pend_d;

  always_comb begin
    run_d  = run_q;
    pend_d = pend_q;
    if (hold) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
    end else if (set_req) begin
      run_d  = 1'b1;
      pend_d = 1'b0;
    end else if (clr_req) begin
      if (run_q) pend_d = 1'b1;
    end else if (frame_done && run_q && (pend_q || !keep_running)) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pend_q <= pend_d;
    end
  end

  AST_PENDING_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> run_q); // R9

  AST_RUN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(frame_done) || $past(hold))); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !hold) |=> (run_q && !pend_q)); // R11

endmodule

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
  import lcd_regs_pkg::*;
#(
  parameter int GATE_DELAY = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [REG_SEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 frame_done,
  output logic                 core_rst_n,
  output logic                 pix_clk_en,
  output logic                 run_active,
  output logic                 master_en,
  output logic [WL_W-1:0]      word_len,
  output logic [FMT_W-1:0]     fmt_flags,
  output logic [MASK_W-1:0]    pack_mask,
  output logic [OUT_W-1:0]     outstanding
);

  acc_mode_e            wr_mode;
  logic [REG_SEL_W-1:0] wr_reg;
  logic                 ctrl_we, fmtw_we;
  logic                 run_set, run_clr;
  logic                 srst_q, srst_d, gate_q, run_q;
  logic                 hold;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] fmtw_q, fmtw_d;
  logic [DATA_W-1:0] cur_word    [NUM_REGS];
  logic [DATA_W-1:0] merged_word [NUM_REGS];

  // address decode
  always_comb begin
    wr_mode = acc_mode_e'(wr_addr[MODE_W-1:0]);
    wr_reg  = wr_addr[ADDR_W-1:MODE_W];
    ctrl_we = wr_en && (wr_reg == REG_SEL_W'(0)) && (wr_mode != MODE_NONE);
    fmtw_we = wr_en && (wr_reg == REG_SEL_W'(1)) && (wr_mode != MODE_NONE);
  end

  // run intent depends only on data bit 0 of a control write
  always_comb begin
    run_set = 1'b0;
    run_clr = 1'b0;
    if (ctrl_we) begin
      case (wr_mode)
        MODE_WRITE: begin
          run_set = wr_data[CT_RUN];
          run_clr = !wr_data[CT_RUN];
        end
        MODE_SET:   run_set = wr_data[CT_RUN];
        MODE_CLEAR: run_clr = wr_data[CT_RUN];
        default: ;
      endcase
    end
  end

  // visible register words
  always_comb begin
    cur_word[0]          = ctrl_q;
    cur_word[0][CT_RUN]  = run_q;
    cur_word[0][CT_GATE] = gate_q;
    cur_word[0][CT_SRST] = srst_q;
    cur_word[1]          = fmtw_q;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_merge
      lcd_alias_merge #(.W(DATA_W)) i_merge (
        .cur    (cur_word[g]),
        .wdata  (wr_data),
        .mode   (wr_mode),
        .merged (merged_word[g])
      );
    end
  endgenerate

  lcd_reset_handshake #(.GATE_DELAY(GATE_DELAY)) i_handshake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (ctrl_we),
    .sw_srst (merged_word[0][CT_SRST]),
    .sw_gate (merged_word[0][CT_GATE]),
    .srst_q  (srst_q),
    .srst_d  (srst_d),
    .gate_q  (gate_q)
  );

  always_comb hold = srst_q || srst_d;

  lcd_run_ctrl i_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (hold),
    .set_req      (run_set),
    .clr_req      (run_clr),
    .frame_done   (frame_done),
    .keep_running (ctrl_q[CT_KEEP]),
    .run_q        (run_q)
  );

  // field registers: next state
  always_comb begin
    ctrl_d = ctrl_q;
    fmtw_d = fmtw_q;
    if (hold) begin
      ctrl_d = '0;
      fmtw_d = FMT_WORD_RST;
    end else begin
      if (ctrl_we) ctrl_d = merged_word[0] & CTRL_SOFT_MASK;
      if (fmtw_we) fmtw_d = merged_word[1] & FMT_WORD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fmtw_q <= FMT_WORD_RST;
    end else begin
      ctrl_q <= ctrl_d;
      fmtw_q <= fmtw_d;
    end
  end

  // outputs
  always_comb begin
    rd_data     = cur_word[rd_sel];
    core_rst_n  = !srst_q;
    pix_clk_en  = !gate_q;
    run_active  = run_q;
    master_en   = ctrl_q[CT_MASTER];
    word_len    = ctrl_q[CT_WL_LO +: WL_W];
    fmt_flags   = ctrl_q[CT_FMT_LO +: FMT_W];
    pack_mask   = fmtw_q[FW_MASK_LO +: MASK_W];
    outstanding = fmtw_q[FW_OUT_LO +: OUT_W];
  end

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (ctrl_q == '0 && fmtw_q == FMT_WORD_RST)); // R5

  AST_NONE_MODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_NONE && !srst_q) |=> ($stable(ctrl_q) && $stable(fmtw_q))); // R2

  AST_RESET_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_d && !srst_q) |=> !run_active); // R5

endmodule

// File: tb/test_lcd_ctrl_regs.sv
module test_lcd_ctrl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int GD = 4;

  logic        clk, rst_n, wr_en, frame_done;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data, rd_data;
  logic [0:0]  rd_sel;
  logic        core_rst_n, pix_clk_en, run_active, master_en;
  logic [1:0]  word_len;
  logic [2:0]  fmt_flags, outstanding;
  logic [3:0]  pack_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  lcd_ctrl_regs #(.GATE_DELAY(GD)) i_lcd_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .frame_done(frame_done),
    .core_rst_n(core_rst_n), .pix_clk_en(pix_clk_en), .run_active(run_active),
    .master_en(master_en), .word_len(word_len), .fmt_flags(fmt_flags),
    .pack_mask(pack_mask), .outstanding(outstanding)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // cycle model built from the requirements
  logic m_srst, m_gate, m_busy, m_master, m_keep, m_run, m_pend;
  int   m_cnt;
  logic [1:0] m_wl;
  logic [2:0] m_fmt, m_out;
  logic [3:0] m_mask;

  function automatic logic [31:0] m_ctrl_word();
    return {m_srst, m_gate, 19'b0, m_fmt, 2'b0, m_wl, 1'b0, m_keep, m_master, m_run};
  endfunction

  function automatic logic [31:0] m_fmt_word();
    return {25'b0, m_out, m_mask};
  endfunction

  task automatic model_reset();
    m_srst = 1; m_gate = 1; m_busy = 0; m_cnt = 0;
    m_master = 0; m_keep = 0; m_run = 0; m_pend = 0;
    m_wl = 0; m_fmt = 0; m_mask = 4'hF; m_out = 3'd4;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [31:0] d,
                            input logic fd);
    logic [31:0] cur, mg;
    logic cwe, fwe, setq, clrq, nrst, ngate, hold;
    logic [1:0] md;
    md  = a[1:0];
    cwe = we && !a[2] && md != 2'd3;
    fwe = we && a[2] && md != 2'd3;
    cur = a[2] ? m_fmt_word() : m_ctrl_word();
    case (md)
      2'd0:    mg = d;
      2'd1:    mg = cur | d;
      default: mg = cur & ~d;
    endcase
    setq = 0; clrq = 0;
    if (cwe) begin
      case (md)
        2'd0: begin setq = d[0]; clrq = !d[0]; end
        2'd1: setq = d[0];
        default: clrq = d[0];
      endcase
    end
    nrst  = cwe ? mg[31] : m_srst;
    ngate = cwe ? mg[30] : m_gate;
    if (m_busy && m_cnt == 0 && nrst) ngate = 1;
    if (!m_srst && nrst) begin
      m_busy = 1; m_cnt = GD - 1;
    end else if (m_busy) begin
      if (!nrst || m_cnt == 0) m_busy = 0;
      else m_cnt = m_cnt - 1;
    end
    hold = m_srst || nrst;
    if (hold) begin
      m_run = 0; m_pend = 0;
    end else if (setq) begin
      m_run = 1; m_pend = 0;
    end else if (clrq) begin
      if (m_run) m_pend = 1;
    end else if (fd && m_run && (m_pend || !m_keep)) begin
      m_run = 0; m_pend = 0;
    end
    if (hold) begin
      m_master = 0; m_keep = 0; m_wl = 0; m_fmt = 0; m_mask = 4'hF; m_out = 3'd4;
    end else begin
      if (cwe) begin
        m_master = mg[1]; m_keep = mg[2]; m_wl = mg[5:4]; m_fmt = mg[10:8];
      end
      if (fwe) begin
        m_mask = mg[3:0]; m_out = mg[6:4];
      end
    end
    m_srst = nrst;
    m_gate = ngate;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic fd);
    wr_en = we; wr_addr = a; wr_data = d; frame_done = fd;
    model_step(we, a, d, fd);
    @(negedge clk);
    wr_en = 0; frame_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 3'd0, 32'h0, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v, w;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; frame_done = 0; rd_sel = 0;
    model_reset();
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, v); chk("R1 ctrl reset", v, 32'hC000_0000);
    rd(1, v); chk("R1 fmt reset", v, 32'h0000_004F);
    chk("R1 pins", {core_rst_n, pix_clk_en, run_active}, 3'b000);

    // R5 writes ignored while in reset, gate cleared by software
    tick(1, 3'd0, 32'h8000_0007, 0);
    rd(0, v); chk("R5 ctrl held", v, 32'h8000_0000);
    chk("R8 pins after gate clear", {core_rst_n, pix_clk_en}, 2'b01);
    tick(1, 3'd4, 32'h0000_0015, 0);
    rd(1, v); chk("R5 fmt held", v, 32'h0000_004F);

    // R6 re-setting soft reset starts no handshake
    tick(1, 3'd1, 32'h8000_0000, 0);
    idle(GD + 2);
    rd(0, v); chk("R6 no new handshake", v, 32'h8000_0000);
    tick(1, 3'd2, 32'h8000_0000, 0);
    rd(0, v); chk("R6 release", v, 32'h0000_0000);
    chk("R8 core out of reset", {core_rst_n, pix_clk_en}, 2'b11);

    // R3 field layout
    tick(1, 3'd0, 32'h0000_0736, 0);
    rd(0, v); chk("R3 ctrl fields", v, 32'h0000_0736);
    chk("R3 ctrl outputs", {master_en, word_len, fmt_flags}, {1'b1, 2'd3, 3'd7});
    tick(1, 3'd4, 32'hFFFF_FFFF, 0);
    rd(1, v); chk("R3 fmt reserved zero", v, 32'h0000_007F);

    // R2 aliases
    tick(1, 3'd6, 32'h0000_000F, 0);
    rd(1, v); chk("R2 clear alias", v, 32'h0000_0070);
    tick(1, 3'd5, 32'h0000_0005, 0);
    rd(1, v); chk("R2 set alias", v, 32'h0000_0075);
    tick(1, 3'd3, 32'hFFFF_FFFF, 0);
    tick(1, 3'd7, 32'hFFFF_FFFF, 0);
    rd(0, v); rd(1, w);
    chk("R2 mode 3 ignored", {v, w} == {32'h0000_0736, 32'h0000_0075}, 1);
    chk("R3 fmt outputs", {pack_mask, outstanding}, {4'h5, 3'd7});

    // R9 stop deferred to frame end
    tick(1, 3'd1, 32'h1, 0);
    chk("R9 run set", run_active, 1);
    tick(1, 3'd2, 32'h1, 1);
    chk("R9 same-cycle frame ignored", run_active, 1);
    idle(3);
    rd(0, v); chk("R9 still reads 1", v, 32'h0000_0737);
    tick(0, 3'd0, 0, 1);
    chk("R9 stop at frame end", run_active, 0);

    // R11 alias writes without bit 0 keep pending stop
    tick(1, 3'd1, 32'h1, 0);
    tick(1, 3'd2, 32'h1, 0);
    tick(1, 3'd1, 32'h2, 0);
    tick(0, 3'd0, 0, 1);
    chk("R11 set alias bit0=0 keeps stop", run_active, 0);
    tick(1, 3'd1, 32'h1, 0);
    tick(1, 3'd2, 32'h1, 0);
    tick(1, 3'd1, 32'h1, 0);
    tick(0, 3'd0, 0, 1);
    chk("R11 set cancels stop", run_active, 1);
    tick(1, 3'd2, 32'h0, 1);
    chk("R11 clear alias bit0=0 no effect", run_active, 1);

    // R10 single-frame mode
    tick(1, 3'd2, 32'h4, 0);
    rd(0, v); chk("R10 keep cleared", v, 32'h0000_0733);
    tick(0, 3'd0, 0, 1);
    chk("R10 falls at frame end", run_active, 0);
    tick(1, 3'd1, 32'h1, 1);
    chk("R10 same-cycle frame ignored", run_active, 1);
    idle(1);
    tick(0, 3'd0, 0, 1);
    chk("R10 next frame ends run", run_active, 0);

    // R4 handshake timing
    tick(1, 3'd1, 32'h1, 0);
    tick(1, 3'd1, 32'h8000_0000, 0);
    chk("R5 run drops on reset", run_active, 0);
    idle(GD - 1);
    rd(0, v); chk("R4 gate not yet", v, 32'h8000_0000);
    idle(1);
    rd(0, v); chk("R4 gate raised", v, 32'hC000_0000);
    chk("R8 pins in reset", {core_rst_n, pix_clk_en}, 2'b00);
    tick(1, 3'd2, 32'h4000_0000, 0);
    tick(1, 3'd2, 32'h8000_0000, 0);
    rd(0, v); chk("R5 fields back at reset", v, 32'h0000_0000);
    rd(1, v); chk("R5 fmt back at reset", v, 32'h0000_004F);

    // R7 abort
    tick(1, 3'd1, 32'h8000_0000, 0);
    idle(2);
    tick(1, 3'd2, 32'h8000_0000, 0);
    idle(GD + 2);
    rd(0, v); chk("R7 aborted handshake", v, 32'h0000_0000);
    chk("R7 clock enabled", pix_clk_en, 1);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [2:0] a;
      d = $urandom;
      a = 3'($urandom % 8);
      if (a[1:0] != 2'd2 && d[31] && ($urandom % 8 != 0)) d[31] = 1'b0;
      tick(1'($urandom % 2), a, d, ($urandom % 6) == 0);
      rd(0, v); rd(1, w);
      chk("R2 random register words", (v == m_ctrl_word() && w == m_fmt_word()), 1);
      chk("R8 random pins", {core_rst_n, pix_clk_en, run_active}, {!m_srst, !m_gate, m_run});
    end

    finish_up();
  end

endmodule